// File: doc/BRIEF.md
# Serial Register Access Port

This block is a target-only four-wire serial port. A host controller uses it to read and write a bank of 8-bit configuration and status registers. The block never starts a transfer. A host starts a packet by pulling the select line low. It then clocks bytes through the port, most significant bit first. The serial clock rests low between bytes. The port samples incoming data on the rising serial-clock edge and changes its output on the falling edge.

The first byte of a packet is the command byte. Bits 7 to 5 hold a command code and bits 4 to 0 hold a register address. While the command byte is being clocked in, the port shifts out a status byte that it captured when select went low. The outgoing shifter is refilled only on every eighth falling edge. As a result, the byte that follows a read command already carries the addressed register. A write command commits the following byte to the register bank with a one-cycle strobe.

The serial clock, select and data inputs pass through two-flop synchronizers into the system clock domain. The system clock must run at least four times faster than the serial clock. The output-enable pin tells the pad ring when to drive the shared data-out line. When it is low, the line is released to high impedance.

Top module: `spiRegPort`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges, most significant bit first, in 8-bit bytes. In the first byte of a packet, bits 7..5 are the command and bits 4..0 are the register address.
- R2: While select (`selN`) is high, `serOutEn` is 0 and `serOut` is 0. While select is low, `serOutEn` is 1. Both follow the pin within three system clocks.
- R3: During the command byte, the output shifts out, MSB first, the `statusIn` value captured at the falling edge of select. A fresh value is captured for every packet.
- R4: Command code 000 is a read. Every byte after the command byte carries the addressed register, MSB first. The output shifter is reloaded only at each eighth falling serial-clock edge.
- R5: Command code 100 is a write. After the eighth rising edge of the second byte, `wrStrobe` pulses for exactly one system clock with `wrAddr` = address and `wrData` = that byte. The bank then holds that value.
- R6: In a write packet, bytes after the second cause no strobe. The output carries zeros in every byte after the command byte.
- R7: Any command code other than 000 and 100 causes no strobe for the rest of the packet. The output carries zeros after the command byte.
- R8: Raising select at any point drops a partial byte, clears the bit count so the next packet starts with a fresh command byte, and discards an unfinished write without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low packet select from the host |
| serClk | input | 1 | Serial clock from the host, idles low |
| serIn | input | 1 | Serial data from the host |
| statusIn | input | 8 | Status byte, captured when select falls |
| serOut | output | 1 | Serial data to the host |
| serOutEn | output | 1 | Drive enable for the data-out pad (0 = high impedance) |
| wrStrobe | output | 1 | One-cycle register write strobe |
| wrAddr | output | 5 | Register address of the write |
| wrData | output | 8 | Data of the write |

## Verification
The port is exercised with the following packet types:
- Write packets, both two bytes long and longer. These separate the one committed byte from the ignored trailing bytes.
- Read packets longer than two bytes. These show that the register value repeats at each byte boundary and is not shifted through.
- Packets with rejected command codes. These tell a blocked write apart from an accepted one.
- Packets cut short inside the command byte and inside the data byte. These expose a bit counter or pending write that survives deselection.

Status and data values have asymmetric bit patterns, so a reversed bit order or a one-position shift shows up as a wrong byte. Register addresses 3, 5 and 31 cover both the low and the top address bits.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b000;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b100;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_READ,
    MODE_WRITE,
    MODE_DROP
  } mode_e;

  typedef enum logic [1:0] {
    BYTE_CMD,
    BYTE_DATA,
    BYTE_REST
  } bytePos_e;

  typedef struct packed {
    logic loadStatus;
    logic shiftRx;
    logic shiftTx;
    logic loadTx;
    logic txFromReg;
  } dpCtl_t;

  function automatic mode_e cmdDecode(input logic [CMD_W-1:0] code);
    if (code == CMD_READ)       return MODE_READ;
    else if (code == CMD_WRITE) return MODE_WRITE;
    else                        return MODE_DROP;
  endfunction

endpackage

// File: rtl/spiPortSync.sv
module spiPortSync #(
  parameter int Stages = 2,
  parameter int Width = 1,
  parameter logic [Width-1:0] ResetVal = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);

  logic [Width-1:0] pipe [Stages];

  for (genvar s = 0; s < Stages; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= ResetVal;
      else if (s == 0) pipe[s] <= din;
      else pipe[s] <= pipe[(s > 0) ? s-1 : 0];
    end
  end

  assign dout = pipe[Stages-1];

endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiRegPkg::*;
#(
  parameter int AddrW = 5,
  localparam int DataW = CMD_W + AddrW,
  localparam int CntW = $clog2(DataW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             selS,
  input  logic [DataW-1:0] rxNext,
  output dpCtl_t           dpCtl,
  output logic             selActive,
  output logic [AddrW-1:0] regAddr,
  output logic             wrStrobe,
  output logic [DataW-1:0] wrData
);

  localparam logic [CntW-1:0] LastBit = CntW'(DataW - 1);

  logic sclkD, selD;
  logic sclkRise, sclkFall, selFall, atBoundary;
  logic [CntW-1:0] bitCnt;
  bytePos_e bytePos;
  mode_e mode;

  assign selActive  = !selS;
  assign sclkRise   = sclkS && !sclkD;
  assign sclkFall   = !sclkS && sclkD;
  assign selFall    = !selS && selD;
  assign atBoundary = (bitCnt == '0) && (bytePos != BYTE_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD    <= 1'b0;
      selD     <= 1'b1;
      bitCnt   <= '0;
      bytePos  <= BYTE_CMD;
      mode     <= MODE_IDLE;
      regAddr  <= '0;
      wrStrobe <= 1'b0;
      wrData   <= '0;
    end else begin
      sclkD    <= sclkS;
      selD     <= selS;
      wrStrobe <= 1'b0;
      if (!selActive) begin
        bitCnt  <= '0;
        bytePos <= BYTE_CMD;
        mode    <= MODE_IDLE;
      end else if (sclkRise) begin
        if (bitCnt == LastBit) begin
          bitCnt <= '0;
          unique case (bytePos)
            BYTE_CMD: begin
              regAddr <= rxNext[AddrW-1:0];
              mode    <= cmdDecode(rxNext[DataW-1 -: CMD_W]);
              bytePos <= BYTE_DATA;
            end
            BYTE_DATA: begin
              if (mode == MODE_WRITE) begin
                wrStrobe <= 1'b1;
                wrData   <= rxNext;
              end
              bytePos <= BYTE_REST;
            end
            default: ;
          endcase
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    dpCtl.loadStatus = selFall;
    dpCtl.shiftRx    = selActive && sclkRise;
    dpCtl.shiftTx    = selActive && sclkFall && !atBoundary;
    dpCtl.loadTx     = selActive && sclkFall && atBoundary;
    dpCtl.txFromReg  = (mode == MODE_READ);
  end

endmodule

// File: rtl/spiPortDatapath.sv
module spiPortDatapath
  import spiRegPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic             selActive,
  input  logic             serInS,
  input  logic [DataW-1:0] statusIn,
  input  logic [DataW-1:0] rdData,
  output logic [DataW-1:0] rxNext,
  output logic             serOut
);

  logic [DataW-1:0] rxShift, txShift;

  assign rxNext = {rxShift[DataW-2:0], serInS};
  assign serOut = selActive && txShift[DataW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (dpCtl.shiftRx) rxShift <= rxNext;
      if (dpCtl.loadStatus)   txShift <= statusIn;
      else if (dpCtl.loadTx)  txShift <= dpCtl.txFromReg ? rdData : '0;
      else if (dpCtl.shiftTx) txShift <= {txShift[DataW-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spiRegBank.sv
module spiRegBank #(
  parameter int AddrW = 5,
  parameter int DataW = 8,
  localparam int Depth = 1 << AddrW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddr,
  output logic [DataW-1:0] rdData
);

  logic [DataW-1:0] regs [Depth];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) regs[i] <= '0;
    end else if (wrStrobe) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdData = regs[rdAddr];

endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int AddrW = 5,
  parameter int SyncStages = 2,
  localparam int DataW = CMD_W + AddrW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             serClk,
  input  logic             serIn,
  input  logic [DataW-1:0] statusIn,
  output logic             serOut,
  output logic             serOutEn,
  output logic             wrStrobe,
  output logic [AddrW-1:0] wrAddr,
  output logic [DataW-1:0] wrData
);

  logic sclkS, selS, serInS, selActive;
  logic [DataW-1:0] rxNext, rdData;
  dpCtl_t dpCtl;

  spiPortSync #(.Stages(SyncStages), .Width(3), .ResetVal(3'b010)) i_sync (
    .clk(clk), .rstN(rstN),
    .din({serClk, selN, serIn}),
    .dout({sclkS, selS, serInS})
  );

  spiPortCtrl #(.AddrW(AddrW)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .selS(selS), .rxNext(rxNext),
    .dpCtl(dpCtl), .selActive(selActive), .regAddr(wrAddr),
    .wrStrobe(wrStrobe), .wrData(wrData)
  );

  spiPortDatapath #(.DataW(DataW)) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .selActive(selActive),
    .serInS(serInS), .statusIn(statusIn), .rdData(rdData),
    .rxNext(rxNext), .serOut(serOut)
  );

  spiRegBank #(.AddrW(AddrW), .DataW(DataW)) i_bank (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(wrAddr), .rdData(rdData)
  );

  assign serOutEn = selActive;

endmodule

// File: rtl/spiRegPortChecker.sv
module spiRegPortChecker (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic serOut,
  input logic serOutEn,
  input logic wrStrobe
);

  AST_OUT_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !serOutEn |-> !serOut); // R2

  AST_HIZ_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    (selN && $past(selN) && $past(selN, 2)) |-> !serOutEn); // R2

  AST_DRIVE_WHEN_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !$past(selN) && !$past(selN, 2)) |-> serOutEn); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R5

  AST_STROBE_IN_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !$past(selN, 3)); // R8

endmodule

bind spiRegPort spiRegPortChecker i_spiRegPortChecker (
  .clk(clk), .rstN(rstN), .selN(selN), .serOut(serOut),
  .serOutEn(serOutEn), .wrStrobe(wrStrobe)
);

// File: tb/test_spiRegPort.sv
module test_spiRegPort;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, selN = 1'b1, serClk = 1'b0, serIn = 1'b0;
  logic [7:0] statusIn = 8'h00;
  logic serOut, serOutEn, wrStrobe;
  logic [4:0] wrAddr;
  logic [7:0] wrData;

  spiRegPort i_spiRegPort (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk), .serIn(serIn),
    .statusIn(statusIn), .serOut(serOut), .serOutEn(serOutEn),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

  typedef struct {
    string req;
    logic [15:0] val;
  } item_t;

  item_t expByte[$];
  item_t expWr[$];
  logic [15:0] obsByte[$];
  logic [15:0] obsWr[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: records strobes, pairs observed items with expected ones
  always @(negedge clk) begin
    if (rstN && wrStrobe) obsWr.push_back({3'b000, wrAddr, wrData});
    while (expByte.size() > 0 && obsByte.size() > 0) begin
      item_t e;
      e = expByte.pop_front();
      check(e.req, obsByte.pop_front(), e.val);
    end
    while (expWr.size() > 0 && obsWr.size() > 0) begin
      item_t e;
      e = expWr.pop_front();
      check(e.req, obsWr.pop_front(), e.val);
    end
  end

  task automatic halfWait();
    repeat (6) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nBits; i++) begin
      serIn = tx[7-i];
      halfWait();
      rx = {rx[6:0], serOut};
      serClk = 1'b1;
      halfWait();
      serClk = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] tx, input logic [7:0] exp, input string req);
    logic [7:0] r;
    expByte.push_back('{req, {8'h00, exp}});
    xferBits(tx, 8, r);
    obsByte.push_back({8'h00, r});
  endtask

  task automatic expectWrite(input logic [4:0] a, input logic [7:0] d);
    expWr.push_back('{"R5", {3'b000, a, d}});
  endtask

  task automatic startPkt(input logic [7:0] st);
    statusIn = st;
    selN = 1'b0;
    halfWait();
  endtask

  task automatic endPkt();
    selN = 1'b1;
    halfWait();
    halfWait();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset oe", 16'(serOutEn), 16'h0);
    check("R2 reset out", 16'(serOut), 16'h0);
    check("R5 reset strobe", 16'(wrStrobe), 16'h0);

    // write 0x3C to register 3 (command 100, address 00011)
    startPkt(8'hA5);
    check("R2 oe on", 16'(serOutEn), 16'h1);
    sendByte(8'h83, 8'hA5, "R3");
    expectWrite(5'd3, 8'h3C);
    sendByte(8'h3C, 8'h00, "R6");
    endPkt();
    check("R2 oe off", 16'(serOutEn), 16'h0);
    check("R2 out off", 16'(serOut), 16'h0);

    // read register 3 over three bytes
    startPkt(8'h5A);
    sendByte(8'h03, 8'h5A, "R3");
    sendByte(8'h00, 8'h3C, "R4");
    sendByte(8'hFF, 8'h3C, "R4");
    endPkt();

    // write register 31, trailing bytes ignored
    startPkt(8'h01);
    sendByte(8'h9F, 8'h01, "R1");
    expectWrite(5'd31, 8'h81);
    sendByte(8'h81, 8'h00, "R5");
    sendByte(8'h55, 8'h00, "R6");
    sendByte(8'h66, 8'h00, "R6");
    endPkt();
    check("R6 no extra strobe", 16'(obsWr.size()), 16'h0);

    startPkt(8'hC3);
    sendByte(8'h1F, 8'hC3, "R3");
    sendByte(8'h00, 8'h81, "R4");
    endPkt();

    // rejected command codes 001, 101, 011 on address 3
    foreach (expByte[i]) ;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] c;
      c = (k == 0) ? 8'h23 : (k == 1) ? 8'hA3 : 8'h63;
      startPkt(8'h00);
      sendByte(c, 8'h00, "R7");
      sendByte(8'hFF, 8'h00, "R7");
      endPkt();
      check("R7 no strobe", 16'(obsWr.size()), 16'h0);
    end
    startPkt(8'h00);
    sendByte(8'h03, 8'h00, "R7");
    sendByte(8'h00, 8'h3C, "R7 reg kept");
    endPkt();

    // abort inside the data byte of a write
    startPkt(8'h00);
    sendByte(8'h83, 8'h00, "R8");
    xferBits(8'hEE, 4, junk);
    endPkt();
    check("R8 write dropped", 16'(obsWr.size()), 16'h0);
    startPkt(8'h00);
    sendByte(8'h03, 8'h00, "R8");
    sendByte(8'h00, 8'h3C, "R8 reg kept");
    endPkt();

    // abort inside the command byte, then a clean write
    startPkt(8'h77);
    xferBits(8'h9F, 3, junk);
    endPkt();
    startPkt(8'h12);
    sendByte(8'h85, 8'h12, "R8 fresh packet");
    expectWrite(5'd5, 8'h99);
    sendByte(8'h99, 8'h00, "R5");
    endPkt();
    startPkt(8'h48);
    sendByte(8'h05, 8'h48, "R1");
    sendByte(8'h00, 8'h99, "R1");
    endPkt();

    repeat (10) @(negedge clk);
    check("R5 queues drained",
          16'(expByte.size() + obsByte.size() + expWr.size() + obsWr.size()), 16'h0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule